// File: doc/BRIEF.md
# Sensor Fusion and Event Unit

This block keeps a set of derived quantities current without host effort. A bank of signed sensor inputs streams in on every clock. The unit holds a number of function slots. Each slot has a sensor selection mask, one signed weight per sensor, an event comparison mode and two thresholds. A scheduler visits one slot per clock in fixed rotation. On that visit every selected sensor is multiplied by its weight, the products are summed in an adder tree, and the sum is written into that slot's result register.

In the same clock the fresh sum is compared against the slot's event condition. A true condition sets a sticky status bit for that slot. The interrupt line is raised while any status bit whose interrupt enable is set is high. The host programs slots through a single write port and clears status bits by writing ones. It reads any result through a combinational read port, so a read takes the same time whatever the slot's sensor count.

Top module: `sfe_unit`

## Requirements
- R1: While reset is held, and just after it, every result reads 0, every status bit is 0 and `irq_o` is low.
- R2: A slot's result is the exact signed sum, over the sensors selected in its mask, of sensor value times weight. Sensor k occupies `sens_i[16k+15:16k]`. With 8 sensors, 16-bit data and 12-bit weights, the 31-bit result never overflows, including all sensors at -32768 with all weights at -2048.
- R3: A sensor whose mask bit is 0 contributes nothing, whatever its weight. A slot with an all-zero mask reads 0.
- R4: Slots are evaluated in rotation, one per clock. After the sensors change and then stay steady, every result reflects the new values once 8 clock edges have passed, with no host action.
- R5: `rd_data` shows the result of slot `rd_fn` in the same cycle that `rd_fn` is applied, with no clock edge needed.
- R6: The write address is `{slot[2:0], field[3:0]}`. Fields 0 to 7 hold the weight of sensor k in `cfg_wdata[11:0]`. Field 8 holds the mask in bits [7:0]. Field 9 holds the mode in bits [2:0] and the interrupt enable in bit 3. Field 10 holds threshold A and field 11 holds threshold B, both signed in bits [30:0]. The mode codes are: 1 sets status when result < A; 2 when result > A; 3 when result == A; 4 when A <= result <= B; 5 when result < A or result > B. All comparisons are signed.
- R7: A status bit stays set until the host writes field 12 with a 1 in that slot's bit of `cfg_wdata[7:0]`. Bits written 0 are unaffected. If the condition still holds, the bit sets again at the slot's next evaluation.
- R8: `irq_o` is the OR of the status bits whose interrupt enable is 1. A status bit still sets when its enable is 0.
- R9: A configuration write takes effect at the slot's next evaluation. The slot's result keeps its previous value until that evaluation.
- R10: Mode 0, and the unused codes 6 and 7, never set a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sens_i | input | 128 | Eight signed 16-bit sensor samples, sensor k at bits [16k+15:16k] |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Slot index in [6:4], field code in [3:0] |
| cfg_wdata | input | 32 | Write data |
| rd_fn | input | 3 | Slot whose result is read |
| rd_data | output | 31 | Signed result of slot `rd_fn` |
| status_o | output | 8 | Sticky per-slot event status |
| irq_o | output | 1 | Interrupt request |

## Verification
The summing path is driven with five sensor patterns: all zeros, small distinct positive values, every sensor at the positive limit, every sensor at the negative limit, and mixed signs around a large value. Slots use all-ones, all-minus-2048, sparse and empty masks. The limit patterns separate signed from unsigned products and expose a truncated accumulator. The sparse and empty masks show whether masked sensors leak into the sum. The event modes are tried against a fixed result with thresholds just below, at and just above it, including a negative threshold, so off-by-one boundaries and unsigned comparison each fail a check.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [2:0] {
        EV_OFF = 3'd0,
        EV_LT  = 3'd1,
        EV_GT  = 3'd2,
        EV_EQ  = 3'd3,
        EV_IN  = 3'd4,
        EV_OUT = 3'd5
    } ev_mode_e;

    localparam int FLD_W = 4;

    // Field codes inside the low nibble of the configuration address.
    // Codes 0..7 (bit 3 clear) address the weight of sensor k.
    localparam logic [FLD_W-1:0] FLD_MASK = 4'd8;
    localparam logic [FLD_W-1:0] FLD_MODE = 4'd9;
    localparam logic [FLD_W-1:0] FLD_THA  = 4'd10;
    localparam logic [FLD_W-1:0] FLD_THB  = 4'd11;
    localparam logic [FLD_W-1:0] FLD_CLR  = 4'd12;

    localparam int MODE_IEN_BIT = 3;

endpackage

// File: rtl/sfe_dot.sv
// Parallel weighted sum: one multiplier per sensor, then a balanced adder tree.
module sfe_dot #(
    parameter int NS = 8,
    parameter int SW = 16,
    parameter int WW = 12,
    parameter int RW = SW + WW + $clog2(NS)
) (
    input  logic [NS*SW-1:0]     sens_i,
    input  logic [NS*WW-1:0]     wgt_i,
    input  logic [NS-1:0]        mask_i,
    output logic signed [RW-1:0] sum_o
);

    localparam int PW  = SW + WW;
    localparam int LVL = $clog2(NS);
    localparam int NP  = 1 << LVL;

    logic signed [RW-1:0] node [1:2*NP-1];

    generate
        for (genvar k = 0; k < NP; k++) begin : g_leaf
            if (k < NS) begin : g_used
                logic signed [PW-1:0] prod;
                logic        [WW-1:0] wsel;
                // a masked sensor is treated as having weight zero
                assign wsel = mask_i[k] ? wgt_i[k*WW +: WW] : '0;
                assign prod = $signed(sens_i[k*SW +: SW]) * $signed(wsel);
                assign node[NP+k] = {{(RW-PW){prod[PW-1]}}, prod};
            end else begin : g_pad
                assign node[NP+k] = '0;
            end
        end
        for (genvar i = 1; i < NP; i++) begin : g_tree
            assign node[i] = node[2*i] + node[2*i+1];
        end
    endgenerate

    assign sum_o = node[1];

endmodule

// File: rtl/sfe_event.sv
// Signed threshold / range comparison of one result.
module sfe_event
    import sfe_pkg::*;
#(
    parameter int RW = 31
) (
    input  logic signed [RW-1:0] val_i,
    input  logic signed [RW-1:0] tha_i,
    input  logic signed [RW-1:0] thb_i,
    input  logic [2:0]           mode_i,
    output logic                 hit_o
);

    always_comb begin
        case (mode_i)
            EV_LT:   hit_o = (val_i < tha_i);
            EV_GT:   hit_o = (val_i > tha_i);
            EV_EQ:   hit_o = (val_i == tha_i);
            EV_IN:   hit_o = (val_i >= tha_i) && (val_i <= thb_i);
            EV_OUT:  hit_o = (val_i < tha_i) || (val_i > thb_i);
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sfe_cfg_bank.sv
// Per-slot configuration storage, write decode and selected-slot readout.
module sfe_cfg_bank
    import sfe_pkg::*;
#(
    parameter int NS  = 8,
    parameter int WW  = 12,
    parameter int NF  = 8,
    parameter int RW  = 31,
    parameter int DW  = 32,
    localparam int FNW = $clog2(NF),
    localparam int AW  = FNW + FLD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [DW-1:0]        wdata_i,
    input  logic [FNW-1:0]       sel_i,
    output logic [NS*WW-1:0]     cur_wgt_o,
    output logic [NS-1:0]        cur_mask_o,
    output logic [2:0]           cur_mode_o,
    output logic signed [RW-1:0] cur_tha_o,
    output logic signed [RW-1:0] cur_thb_o,
    output logic [NF-1:0]        ien_o,
    output logic [NF-1:0]        clr_o
);

    typedef struct packed {
        logic [NF-1:0][NS*WW-1:0] wgt;
        logic [NF-1:0][NS-1:0]    mask;
        logic [NF-1:0][2:0]       mode;
        logic [NF-1:0]            ien;
        logic [NF-1:0][RW-1:0]    tha;
        logic [NF-1:0][RW-1:0]    thb;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [FNW-1:0]   wr_fn;
    logic [FLD_W-1:0] wr_fld;

    assign wr_fn  = addr_i[AW-1:FLD_W];
    assign wr_fld = addr_i[FLD_W-1:0];

    always_comb begin
        cfg_d = cfg_q;
        if (we_i && (int'(wr_fn) < NF)) begin
            if (!wr_fld[3]) begin
                for (int k = 0; k < NS; k++) begin
                    if (wr_fld[2:0] == 3'(k)) begin
                        cfg_d.wgt[wr_fn][k*WW +: WW] = wdata_i[WW-1:0];
                    end
                end
            end
            case (wr_fld)
                FLD_MASK: cfg_d.mask[wr_fn] = wdata_i[NS-1:0];
                FLD_MODE: begin
                    cfg_d.mode[wr_fn] = wdata_i[2:0];
                    cfg_d.ien[wr_fn]  = wdata_i[MODE_IEN_BIT];
                end
                FLD_THA:  cfg_d.tha[wr_fn] = wdata_i[RW-1:0];
                FLD_THB:  cfg_d.thb[wr_fn] = wdata_i[RW-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign clr_o      = (we_i && (wr_fld == FLD_CLR)) ? wdata_i[NF-1:0] : '0;
    assign cur_wgt_o  = cfg_q.wgt[sel_i];
    assign cur_mask_o = cfg_q.mask[sel_i];
    assign cur_mode_o = cfg_q.mode[sel_i];
    assign cur_tha_o  = cfg_q.tha[sel_i];
    assign cur_thb_o  = cfg_q.thb[sel_i];
    assign ien_o      = cfg_q.ien;

    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cfg_q.mask));

endmodule

// File: rtl/sfe_unit.sv
// Round-robin weighted-sum engine with result file and sticky event status.
module sfe_unit
    import sfe_pkg::*;
#(
    parameter int NS  = 8,
    parameter int SW  = 16,
    parameter int WW  = 12,
    parameter int NF  = 8,
    parameter int DW  = 32,
    localparam int RW  = SW + WW + $clog2(NS),
    localparam int FNW = $clog2(NF),
    localparam int AW  = FNW + FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NS*SW-1:0]  sens_i,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic [FNW-1:0]    rd_fn,
    output logic [RW-1:0]     rd_data,
    output logic [NF-1:0]     status_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [FNW-1:0]         ptr;
        logic [NF-1:0][RW-1:0]  res;
        logic [NF-1:0]          sts;
    } state_t;

    state_t st_d, st_q;

    logic [NS*WW-1:0]     cur_wgt;
    logic [NS-1:0]        cur_mask;
    logic [2:0]           cur_mode;
    logic signed [RW-1:0] cur_tha;
    logic signed [RW-1:0] cur_thb;
    logic [NF-1:0]        ien;
    logic [NF-1:0]        clr;
    logic signed [RW-1:0] sum;
    logic                 hit;

    sfe_cfg_bank #(
        .NS(NS), .WW(WW), .NF(NF), .RW(RW), .DW(DW)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we),
        .addr_i     (cfg_addr),
        .wdata_i    (cfg_wdata),
        .sel_i      (st_q.ptr),
        .cur_wgt_o  (cur_wgt),
        .cur_mask_o (cur_mask),
        .cur_mode_o (cur_mode),
        .cur_tha_o  (cur_tha),
        .cur_thb_o  (cur_thb),
        .ien_o      (ien),
        .clr_o      (clr)
    );

    sfe_dot #(
        .NS(NS), .SW(SW), .WW(WW), .RW(RW)
    ) u_dot (
        .sens_i (sens_i),
        .wgt_i  (cur_wgt),
        .mask_i (cur_mask),
        .sum_o  (sum)
    );

    sfe_event #(
        .RW(RW)
    ) u_event (
        .val_i  (sum),
        .tha_i  (cur_tha),
        .thb_i  (cur_thb),
        .mode_i (cur_mode),
        .hit_o  (hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ptr = (st_q.ptr == FNW'(NF-1)) ? '0 : st_q.ptr + 1'b1;
        st_d.res[st_q.ptr] = sum;
        st_d.sts = st_q.sts & ~clr;
        if (hit) begin
            st_d.sts[st_q.ptr] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.res[rd_fn];
    assign status_o = st_q.sts;
    assign irq_o    = |(st_q.sts & ien);

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ptr == FNW'(NF-1)) |=> (st_q.ptr == '0));

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(cfg_we));

    generate
        for (genvar i = 0; i < NF; i++) begin : g_chk
            // R9
            res_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(st_q.res[i]) |-> ($past(st_q.ptr) == FNW'(i)));
            // R10
            sts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.sts[i]) |-> (($past(st_q.ptr) == FNW'(i)) &&
                                        ($past(cur_mode) != EV_OFF)));
        end
    endgenerate

endmodule

// File: tb/sfe_unit_bench.sv
`timescale 1ns/1ps
module sfe_unit_bench;

    localparam int NF = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] sens_i = '0;
    logic         cfg_we = 1'b0;
    logic [6:0]   cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic [2:0]   rd_fn = '0;
    logic [30:0]  rd_data;
    logic [7:0]   status_o;
    logic         irq_o;

    int total = 0;
    int fails = 0;

    int          b_wgt [8][8];
    logic [7:0]  b_mask [8];

    always #10 clk = ~clk;

    sfe_unit u_sfe_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .sens_i    (sens_i),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rd_fn     (rd_fn),
        .rd_data   (rd_data),
        .status_o  (status_o),
        .irq_o     (irq_o)
    );

    // stimulus: sensor patterns, sensor 0 in the low 16 bits
    localparam logic [127:0] PAT [5] = '{
        128'h0,
        {16'd8, 16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1},
        {8{16'h7FFF}},
        {8{16'h8000}},
        {16'hFFF9, 16'd6, 16'hFFFB, 16'd4, 16'hFFFD, 16'd2, 16'hFFFF, 16'd1000}
    };
    // expected result of slot 0 (all weights 1, full mask) per pattern
    localparam longint EXP0 [5] = '{0, 36, 262136, -262144, 996};

    // event cases against a result of 36: mode, A, B, expected status
    localparam int EV_M [14] = '{1, 1, 2, 2, 3, 3, 4, 4, 4, 5, 5, 2, 1, 0};
    localparam int EV_A [14] = '{37, 36, 35, 36, 36, 35, 36, 37, 30, 37, 36, -5, -5, 0};
    localparam int EV_B [14] = '{0, 0, 0, 0, 0, 0, 40, 40, 36, 40, 36, 0, 0, 0};
    localparam int EV_X [14] = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 1, 0, 1, 0, 0};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int fn, input int fld, input logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {3'(fn), 4'(fld)};
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic read_res(input int fn, output longint val);
        rd_fn = 3'(fn);
        #1;
        val = longint'($signed(rd_data));
    endtask

    function automatic longint model(input int f, input logic [127:0] pat);
        longint s = 0;
        for (int k = 0; k < 8; k++) begin
            if (b_mask[f][k]) s += longint'($signed(pat[k*16 +: 16])) * b_wgt[f][k];
        end
        return s;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog R4 actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        longint v;

        // bench-side configuration
        for (int f = 0; f < 8; f++) begin
            for (int k = 0; k < 8; k++) begin
                if (f == 0)      b_wgt[f][k] = 1;
                else if (f == 1) b_wgt[f][k] = -2048;
                else             b_wgt[f][k] = ((f * 5 + k * 3) % 15) - 7;
            end
        end
        b_mask = '{8'hFF, 8'hFF, 8'hAA, 8'h00, 8'h0F, 8'hF0, 8'h81, 8'h7E};

        // R1: reset state
        repeat (3) @(negedge clk);
        for (int f = 0; f < 8; f++) begin
            read_res(f, v);
            chk(v == 0, "R1 result in reset", v, 0);
        end
        chk(status_o == 8'h00, "R1 status in reset", status_o, 0);
        chk(irq_o == 1'b0, "R1 irq in reset", irq_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        read_res(5, v);
        chk(v == 0 && status_o == 0 && irq_o == 0, "R1 after reset", v, 0);

        for (int f = 0; f < 8; f++) begin
            for (int k = 0; k < 8; k++) cfg_write(f, k, 32'(b_wgt[f][k]));
            cfg_write(f, 8, {24'h0, b_mask[f]});
        end

        // R2 R3 R4: walk the pattern table, exactly NF edges after each change
        for (int p = 0; p < 5; p++) begin
            @(negedge clk);
            sens_i = PAT[p];
            repeat (NF) @(posedge clk);
            @(negedge clk);
            read_res(0, v);
            chk(v == EXP0[p], "R2 slot0 vs table", v, EXP0[p]);
            for (int f = 0; f < 8; f++) begin
                read_res(f, v);
                if (f == 2 || f == 3)
                    chk(v == model(f, PAT[p]), "R3 masked sensors", v, model(f, PAT[p]));
                else
                    chk(v == model(f, PAT[p]), "R2 R4 weighted sum", v, model(f, PAT[p]));
            end
        end

        // R5: read without a clock edge
        @(negedge clk);
        read_res(1, v);
        read_res(4, v);
        chk(v == model(4, PAT[4]), "R5 same-cycle read", v, model(4, PAT[4]));

        // settle on a result of 36 in slot 0
        @(negedge clk);
        sens_i = PAT[1];
        repeat (NF + 1) @(negedge clk);

        // R6 R10: event mode table on slot 0
        for (int e = 0; e < 14; e++) begin
            cfg_write(0, 9, 32'(EV_M[e]));
            cfg_write(0, 10, 32'(EV_A[e]));
            cfg_write(0, 11, 32'(EV_B[e]));
            cfg_write(0, 12, 32'h1);
            repeat (NF + 1) @(negedge clk);
            if (EV_M[e] == 0)
                chk(status_o[0] == 1'(EV_X[e]), "R10 disabled mode", status_o[0], EV_X[e]);
            else
                chk(status_o[0] == 1'(EV_X[e]), "R6 event compare", status_o[0], EV_X[e]);
        end

        // R8: status sets without enable; irq follows enable
        cfg_write(0, 10, 32'd36);
        cfg_write(0, 9, 32'd3);
        repeat (NF + 1) @(negedge clk);
        chk(status_o[0] == 1'b1, "R8 status without enable", status_o[0], 1);
        chk(irq_o == 1'b0, "R8 irq masked", irq_o, 0);
        cfg_write(0, 9, 32'd11);
        chk(irq_o == 1'b1, "R8 irq enabled", irq_o, 1);

        // R7: clear semantics
        cfg_write(0, 12, 32'hFE);
        chk(status_o[0] == 1'b1, "R7 zero bit not cleared", status_o[0], 1);
        cfg_write(0, 9, 32'd8);
        cfg_write(0, 12, 32'h1);
        repeat (NF + 1) @(negedge clk);
        chk(status_o[0] == 1'b0 && irq_o == 1'b0, "R7 clear by one", status_o[0], 0);
        cfg_write(0, 9, 32'd11);
        repeat (NF + 1) @(negedge clk);
        cfg_write(0, 12, 32'h1);
        repeat (NF + 1) @(negedge clk);
        chk(status_o[0] == 1'b1, "R7 re-set while true", status_o[0], 1);
        chk(irq_o == 1'b1, "R8 irq on re-set", irq_o, 1);

        // R9: new weight applies at next evaluation, old result held until then
        cfg_write(0, 0, 32'd3);
        read_res(0, v);
        chk(v == 36, "R9 result held after write", v, 36);
        repeat (NF) @(negedge clk);
        read_res(0, v);
        chk(v == 38, "R9 new weight applied", v, 38);

        finish_run();
    end

endmodule